// File: doc/BRIEF.md
# Entry-Path Time-Stamp Sequencer with Trust Flag

This controller drives a separate time-stamp shift register through a fixed query path. It waits in an idle code and starts when a start vector arrives. It then walks 50 transitions through expanded state codes, and each transition must be confirmed by the query vector expected at that step. On the first path state it tells the register to take its seed and enter its constrained mode. After that it pulses a step enable on every accepted transition. After exactly 50 transitions it flags the time-stamp as valid for one cycle, together with a trust bit.

Some path states are checkpoints. In a checkpoint state, the next-state code is also XORed with one nibble of the register's current value, and that nibble has itself been XORed with a constant fixed at elaboration. No equality comparator is applied to the register value. When the register holds the value a genuine seed and tap word would produce, the perturbation is zero and the walk ends on the single legitimate terminal code. A tampered seed or tap word moves the walk onto other codes. The register value is still flagged valid at the end, but trust stays low.

Top module: `tsp_path_fsm`

## Requirements
- R1: While reset is asserted, and on release, the block is idle and all five outputs are 0.
- R2: In idle, only the query vector 13 starts a walk: the next cycle is the load state (code 13, step 0). Any other vector leaves the block idle with all outputs 0.
- R3: `ts_load` is 1 for exactly one cycle per walk, in the step-0 state. `ts_mode` is 1 from that cycle through the terminal cycle.
- R4: At step k (0 to 49) the accepted query is P(k) XOR P(k+1). Here P(0)=13, P(3)=19, P(4)=6, P(20)=37, P(35)=44 and P(50)=21, and every other P(k) is 64+k. Any other vector returns the block to idle in the next cycle.
- R5: `ts_step` is 1 for each accepted transition out of steps 1 to 49, which makes 49 pulses per complete walk. It is never 1 together with `ts_load`.
- R6: In a checkpoint state the next code also takes a perturbation d. In state 19, d = `lfsr_val[3:0]` XOR `CHK_EXP[3:0]`, applied to the low nibble. In state 37, d = `lfsr_val[7:4]` XOR `CHK_EXP[7:4]`, applied to the high nibble. In state 44, d = `lfsr_val[11:8]` XOR `CHK_EXP[11:8]`, applied to both nibbles.
- R7: `ts_valid` is 1 for exactly one cycle, at step 50. In the next cycle the block is idle, whatever the query vector is.
- R8: `ts_trust` is 1 only when `ts_valid` is 1 and the state code is 21.
- R9: A register that follows the genuine seed and tap word gives trust 1. A changed seed or a changed tap word gives valid 1 with trust 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| query_vec | input | 8 | Query vector for the current step |
| lfsr_val | input | LFSR_W | Current value of the time-stamp register |
| ts_load | output | 1 | Load the seed and select constrained mode |
| ts_mode | output | 1 | Walk in progress (time-stamp mode) |
| ts_step | output | 1 | Advance the time-stamp register by one step |
| ts_valid | output | 1 | Time-stamp value is presented this cycle |
| ts_trust | output | 1 | Walk ended on the legitimate terminal code |

## Verification
The assertions assume that `lfsr_val` changes only after a clock edge, as a register would drive it, and that `query_vec` is stable around each rising edge. The bench drives queries at the falling edge. It plays the register itself, a left-shifting XOR-feedback model that loads on `ts_load` and shifts on `ts_step`, and it updates that value a little after each rising edge. The checkpoint constants are derived from this model's genuine seed and tap word, so only a deliberately altered seed or tap word can make a checkpoint nibble differ.

// File: rtl/tsp_pkg.sv
`timescale 1ns/1ps
package tsp_pkg;
  localparam int STATE_W = 8;
  localparam int NIB_W   = 4;
  localparam int CHK_N   = 3;

  localparam logic [STATE_W-1:0] IDLE_CODE = 8'd0;
  localparam logic [STATE_W-1:0] LOAD_CODE = 8'd13;
  localparam logic [STATE_W-1:0] TERM_CODE = 8'd21;

  // state code that arms checkpoint idx
  function automatic logic [STATE_W-1:0] chk_code(input int idx);
    case (idx)
      0:       return 8'd19;
      1:       return 8'd37;
      default: return 8'd44;
    endcase
  endfunction

  // legitimate code at step k of a walk of the given length
  function automatic logic [STATE_W-1:0] path_code(input int k, input int steps);
    if (k <= 0)     return LOAD_CODE;
    if (k >= steps) return TERM_CODE;
    case (k)
      3:       return 8'd19;
      4:       return 8'd6;
      20:      return 8'd37;
      35:      return 8'd44;
      default: return STATE_W'(64 + k);
    endcase
  endfunction

  // query accepted at step k: moves code k to code k+1
  function automatic logic [STATE_W-1:0] query_code(input int k, input int steps);
    return path_code(k, steps) ^ path_code(k + 1, steps);
  endfunction

  // where a checkpoint's nibble difference lands in the next code
  function automatic logic [STATE_W-1:0] spread(input int idx, input logic [NIB_W-1:0] d);
    case (idx)
      0:       return {4'h0, d};
      1:       return {d, 4'h0};
      default: return {d, d};
    endcase
  endfunction
endpackage

// File: rtl/tsp_step_ctr.sv
`timescale 1ns/1ps
module tsp_step_ctr #(
  parameter int STEPS = 50,
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          advance,
  input  logic          drop,
  output logic          in_path,
  output logic [CW-1:0] step,
  output logic          at_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_path <= 1'b0;
      step    <= '0;
    end else if (start) begin
      in_path <= 1'b1;
      step    <= '0;
    end else if (drop) begin
      in_path <= 1'b0;
      step    <= '0;
    end else if (advance) begin
      step <= step + 1'b1;
    end
  end

  assign at_end = in_path && (step == CW'(STEPS));

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_path |-> (step <= CW'(STEPS)));                               // R7
  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !drop && !start) |=> (step == $past(step) + 1'b1));  // R5
endmodule

// File: rtl/tsp_query_match.sv
`timescale 1ns/1ps
module tsp_query_match
  import tsp_pkg::*;
#(
  parameter int STEPS = 50,
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic               in_path,
  input  logic [CW-1:0]      step,
  input  logic [STATE_W-1:0] query,
  output logic               q_ok
);
  logic [STATE_W-1:0] want;

  always_comb begin
    if (in_path) want = query_code(int'(step), STEPS);
    else         want = LOAD_CODE ^ IDLE_CODE;
    q_ok = (query == want);
  end
endmodule

// File: rtl/tsp_chk_mix.sv
`timescale 1ns/1ps
module tsp_chk_mix
  import tsp_pkg::*;
#(
  parameter int LFSR_W = 16,
  parameter logic [CHK_N*NIB_W-1:0] CHK_EXP = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_path,
  input  logic [STATE_W-1:0] state,
  input  logic [LFSR_W-1:0]  lfsr_val,
  output logic [CHK_N-1:0]   hit,
  output logic [STATE_W-1:0] pert
);
  logic [STATE_W-1:0] term [CHK_N];

  for (genvar g = 0; g < CHK_N; g++) begin : g_chk
    logic [NIB_W-1:0] diff;
    assign hit[g]  = in_path && (state == chk_code(g));
    assign diff    = lfsr_val[g*NIB_W +: NIB_W] ^ CHK_EXP[g*NIB_W +: NIB_W];
    assign term[g] = hit[g] ? spread(g, diff) : '0;
  end

  always_comb begin
    pert = '0;
    for (int i = 0; i < CHK_N; i++) pert = pert ^ term[i];
  end

  AST_CHK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));                                                  // R6
endmodule

// File: rtl/tsp_path_fsm.sv
`timescale 1ns/1ps
module tsp_path_fsm
  import tsp_pkg::*;
#(
  parameter int LFSR_W = 16,
  parameter int STEPS  = 50,
  parameter logic [CHK_N*NIB_W-1:0] CHK_EXP = '0,
  localparam int CW = $clog2(STEPS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] query_vec,
  input  logic [LFSR_W-1:0]  lfsr_val,
  output logic               ts_load,
  output logic               ts_mode,
  output logic               ts_step,
  output logic               ts_valid,
  output logic               ts_trust
);
  logic [STATE_W-1:0] state;
  logic [STATE_W-1:0] pert;
  logic [CHK_N-1:0]   hit;
  logic [CW-1:0]      step;
  logic in_path, at_end, q_ok;
  logic start, advance, drop;

  tsp_query_match #(.STEPS(STEPS)) u_match (
    .in_path(in_path), .step(step), .query(query_vec), .q_ok(q_ok));

  tsp_chk_mix #(.LFSR_W(LFSR_W), .CHK_EXP(CHK_EXP)) u_mix (
    .clk(clk), .rst_n(rst_n), .in_path(in_path), .state(state),
    .lfsr_val(lfsr_val), .hit(hit), .pert(pert));

  assign start   = !in_path && q_ok;
  assign advance = in_path && !at_end && q_ok;
  assign drop    = in_path && (at_end || !q_ok);

  tsp_step_ctr #(.STEPS(STEPS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .drop(drop), .in_path(in_path), .step(step), .at_end(at_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= IDLE_CODE;
    else if (start)   state <= LOAD_CODE;
    else if (drop)    state <= IDLE_CODE;
    else if (advance) state <= state ^ query_vec ^ pert;
  end

  assign ts_load  = in_path && (step == '0);
  assign ts_mode  = in_path;
  assign ts_step  = advance && (step != '0);
  assign ts_valid = at_end;
  assign ts_trust = at_end && (state == TERM_CODE);

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ts_mode && q_ok) |=> (ts_load && state == LOAD_CODE));         // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ts_mode && !q_ok) |=> !ts_mode);                               // R2
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ts_load |=> !ts_load);                                           // R3
  AST_BAD_QUERY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_mode && !ts_valid && !q_ok) |=> !ts_mode);                   // R4
  AST_STEP_NOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ts_step |-> (ts_mode && !ts_load));                              // R5
  AST_VALID_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid |=> (!ts_mode && !ts_valid));                           // R7
  AST_TRUST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ts_trust |-> ts_valid);                                          // R8
endmodule

// File: tb/sim_tsp_path_fsm.sv
`timescale 1ns/1ps
module sim_tsp_path_fsm;
  function automatic logic [15:0] lf_adv(input logic [15:0] s, input logic [15:0] t);
    return {s[14:0], 1'b0} ^ (s[15] ? t : 16'h0000);
  endfunction

  function automatic logic [15:0] lf_run(input logic [15:0] s0, input logic [15:0] t, input int n);
    logic [15:0] s;
    s = s0;
    for (int i = 0; i < n; i++) s = lf_adv(s, t);
    return s;
  endfunction

  localparam logic [15:0] SEED0 = 16'h3A71;
  localparam logic [15:0] TAPS0 = 16'hB40D;
  // the register is loaded at step 0 and shifted from step 1 on, so at step k it has shifted k-1 times
  localparam logic [3:0] E0 = 4'(lf_run(SEED0, TAPS0, 2));
  localparam logic [3:0] E1 = 4'(lf_run(SEED0, TAPS0, 19) >> 4);
  localparam logic [3:0] E2 = 4'(lf_run(SEED0, TAPS0, 34) >> 8);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  query_vec = 8'h00;
  logic [15:0] lfsr_val = 16'h0000;
  logic ts_load, ts_mode, ts_step, ts_valid, ts_trust;

  always #10 clk = ~clk;

  tsp_path_fsm #(.LFSR_W(16), .STEPS(50), .CHK_EXP({E2, E1, E0})) u0 (
    .clk(clk), .rst_n(rst_n), .query_vec(query_vec), .lfsr_val(lfsr_val),
    .ts_load(ts_load), .ts_mode(ts_mode), .ts_step(ts_step),
    .ts_valid(ts_valid), .ts_trust(ts_trust));

  int total = 0;
  int bad = 0;
  int path [0:50];
  logic [15:0] cur_seed, cur_taps;
  // reference model
  bit m_act = 0;
  int m_k = 0;
  int m_st = 0;
  // observations
  int n_load, n_step;
  bit o_valid, o_trust, o_mode;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int b_pert(input int st, input logic [15:0] l);
    if (st == 19) return int'(l[3:0] ^ E0);
    if (st == 37) return int'(l[7:4] ^ E1) * 16;
    if (st == 44) return int'(l[11:8] ^ E2) * 17;
    return 0;
  endfunction

  task automatic cyc(input int q);
    bit e_load, e_mode, e_step, e_valid, e_trust, qok;
    @(negedge clk);
    query_vec = 8'(q);
    #1;
    qok = m_act ? (m_k < 50 && q == (path[m_k] ^ path[m_k + 1])) : (q == 13);
    e_load  = m_act && m_k == 0;
    e_mode  = m_act;
    e_step  = m_act && m_k >= 1 && m_k < 50 && qok;
    e_valid = m_act && m_k == 50;
    e_trust = e_valid && m_st == 21;
    chk(ts_load  == e_load,  "R3", "ts_load",  int'(ts_load),  int'(e_load));
    chk(ts_mode  == e_mode,  "R3", "ts_mode",  int'(ts_mode),  int'(e_mode));
    chk(ts_step  == e_step,  "R5", "ts_step",  int'(ts_step),  int'(e_step));
    chk(ts_valid == e_valid, "R7", "ts_valid", int'(ts_valid), int'(e_valid));
    chk(ts_trust == e_trust, "R8", "ts_trust", int'(ts_trust), int'(e_trust));
    if (ts_load) n_load++;
    if (ts_step) n_step++;
    o_valid = ts_valid;
    o_trust = ts_trust;
    o_mode  = ts_mode;
    @(posedge clk);
    #1;
    if (!m_act) begin
      if (qok) begin m_act = 1; m_k = 0; m_st = 13; end
    end else if (m_k == 50 || !qok) begin
      m_act = 0; m_k = 0; m_st = 0;
    end else begin
      m_st = (m_st ^ q ^ b_pert(m_st, lfsr_val)) & 255;
      m_k++;
    end
    if (e_load)      lfsr_val = cur_seed;
    else if (e_step) lfsr_val = lf_adv(lfsr_val, cur_taps);
  endtask

  task automatic walk(input logic [15:0] seed, input logic [15:0] taps, input bit exp_trust, input string req);
    cur_seed = seed;
    cur_taps = taps;
    n_load = 0;
    n_step = 0;
    cyc(13);
    for (int k = 0; k < 50; k++) cyc(path[k] ^ path[k + 1]);
    cyc(8'h5A);
    chk(o_valid == 1'b1, "R7", "valid at step 50", int'(o_valid), 1);
    chk(o_trust == exp_trust, req, "trust at end", int'(o_trust), int'(exp_trust));
    chk(n_load == 1, "R3", "load pulses", n_load, 1);
    chk(n_step == 49, "R5", "step pulses", n_step, 49);
    cyc(8'h00);
    chk(o_mode == 1'b0, "R7", "idle after valid", int'(o_mode), 0);
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k <= 50; k++) path[k] = 64 + k;
    path[0] = 13; path[3] = 19; path[4] = 6; path[20] = 37; path[35] = 44; path[50] = 21;
    cur_seed = SEED0;
    cur_taps = TAPS0;
    #35;
    chk({ts_load, ts_mode, ts_step, ts_valid, ts_trust} == 5'b0, "R1", "outputs in reset",
        int'({ts_load, ts_mode, ts_step, ts_valid, ts_trust}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: non-start vectors in idle
    cyc(8'h00); cyc(8'h0C); cyc(8'hFF); cyc(8'h12);
    chk(o_mode == 1'b0, "R2", "idle ignores junk", int'(o_mode), 0);
    cyc(8'h00);
    chk(o_mode == 1'b0, "R2", "still idle", int'(o_mode), 0);
    // clean walk: R9 with genuine register
    walk(SEED0, TAPS0, 1'b1, "R9");
    // tampered seed: checkpoints perturb the path (R6)
    walk(SEED0 ^ 16'h0100, TAPS0, 1'b0, "R6");
    // tampered tap word
    walk(SEED0, TAPS0 ^ 16'h0040, 1'b0, "R9");
    // R4: wrong query mid-walk
    cur_seed = SEED0; cur_taps = TAPS0;
    cyc(13);
    for (int k = 0; k < 10; k++) cyc(path[k] ^ path[k + 1]);
    cyc((path[10] ^ path[11]) ^ 1);
    cyc(path[11] ^ path[12]);
    chk(o_mode == 1'b0, "R4", "wrong query returns idle", int'(o_mode), 0);
    // restart after abort
    walk(SEED0, TAPS0, 1'b1, "R8");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule